// File: doc/BRIEF.md
# Receive Link Synchronization Tracker

This block decides whether the ingress data channel of a packet interface is synchronized. It watches a stream of parity-check results, one per received control word. Each result arrives as a strobe with an error flag. The block tracks two states: out-of-sync and in-sync.

To gain sync, the channel must see a programmable run of consecutive clean checks. Once in sync, it drops out after a second programmable run of consecutive failed checks. A disabled interface is held out of sync.

The current state is available in three forms: as a status bit, as a copy handed to the transmit status-channel logic for flow-control handshaking, and as a sticky change event. Software clears the event by writing one to it, and the event can raise an interrupt through an enable.

Top module: `rx_sync_tracker`

## Requirements
- R1: After reset, `sync_o`, `stat_sync_o`, `evt_o` and `irq_o` are all 0.
- R2: While out of sync and enabled, `sync_o` rises at the clock edge that samples the Nth consecutive strobe with `chk_err_i`=0, where N is `acq_thresh_i`. It does not rise earlier.
- R3: While acquiring, a strobe with `chk_err_i`=1 restarts the clean-run count from zero.
- R4: A threshold input programmed to 0 behaves exactly like a threshold of 1.
- R5: While in sync, `sync_o` falls at the edge that samples the Mth consecutive strobe with `chk_err_i`=1, where M is `loss_thresh_i`. Any clean strobe restarts the error-run count.
- R6: With `enable_i`=0, `sync_o` is 0 after the next clock edge and stays 0, whatever strobes arrive.
- R7: `evt_o` is set at the same edge at which `sync_o` changes, in either direction. It stays set until it is cleared.
- R8: A one-cycle `evt_clr_i`=1 clears `evt_o` at the next edge. If a sync change happens in the same cycle, the set wins.
- R9: `irq_o` is 1 exactly when `evt_o`=1 and `irq_en_i`=1. This path is combinational on `irq_en_i`.
- R10: `stat_sync_o` always equals `sync_o`.
- R11: Cycles with `chk_valid_i`=0 leave the state and both run counts unchanged, whatever `chk_err_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Interface enable; 0 holds the tracker out of sync |
| chk_valid_i | input | 1 | Strobe marking one parity-check result |
| chk_err_i | input | 1 | Parity-check failed (qualified by `chk_valid_i`) |
| acq_thresh_i | input | TH_W | Consecutive clean checks needed to gain sync |
| loss_thresh_i | input | TH_W | Consecutive failed checks needed to lose sync |
| evt_clr_i | input | 1 | Write-one-to-clear pulse for the change event |
| irq_en_i | input | 1 | Interrupt enable |
| sync_o | output | 1 | Sync status bit |
| stat_sync_o | output | 1 | Sync indication to the transmit status channel |
| evt_o | output | 1 | Sticky sync-change event |
| irq_o | output | 1 | Event interrupt, gated by `irq_en_i` |

## Verification
The following results are due one rising edge after their stimulus, because each passes through exactly one register:
- a strobe's effect on `sync_o`, `stat_sync_o` and `evt_o`;
- a change on `enable_i`;
- a clear pulse.

`irq_o` is the exception: it follows `irq_en_i` with no edge in between. The bench drives every input on the falling edge and holds it for one full cycle. It then samples the outputs at the next falling edge, so each check lands half a cycle after the single register stage the requirement names. The interrupt-enable check samples before any rising edge.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic {
        SYNC_LOST = 1'b0,
        SYNC_HELD = 1'b1
    } sync_st_e;

endpackage

// File: rtl/rxs_thresh_norm.sv
module rxs_thresh_norm #(
    parameter int W = 4
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] eff_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        eff_o = (raw_i == '0) ? ONE : raw_i;
    end
endmodule

// File: rtl/rxs_sync_fsm.sv
module rxs_sync_fsm
    import rxs_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         enable_i,
    input  logic         chk_valid_i,
    input  logic         chk_err_i,
    input  logic [W-1:0] acq_eff_i,
    input  logic [W-1:0] loss_eff_i,
    output logic         sync_o,
    output logic         chg_o
);
    localparam int CW = W + 1;

    typedef struct packed {
        sync_st_e       st;
        logic [W-1:0]   good_run;
        logic [W-1:0]   bad_run;
    } fsm_t;

    fsm_t state_d, state_q;
    logic [CW-1:0] good_inc, bad_inc;

    always_comb begin
        state_d  = state_q;
        good_inc = {1'b0, state_q.good_run} + CW'(1);
        bad_inc  = {1'b0, state_q.bad_run} + CW'(1);
        if (!enable_i) begin
            state_d.st       = SYNC_LOST;
            state_d.good_run = '0;
            state_d.bad_run  = '0;
        end else if (chk_valid_i) begin
            unique case (state_q.st)
                SYNC_LOST: begin
                    if (chk_err_i) begin
                        state_d.good_run = '0;
                    end else if (good_inc >= {1'b0, acq_eff_i}) begin
                        state_d.st       = SYNC_HELD;
                        state_d.good_run = '0;
                        state_d.bad_run  = '0;
                    end else begin
                        state_d.good_run = good_inc[W-1:0];
                    end
                end
                SYNC_HELD: begin
                    if (!chk_err_i) begin
                        state_d.bad_run = '0;
                    end else if (bad_inc >= {1'b0, loss_eff_i}) begin
                        state_d.st       = SYNC_LOST;
                        state_d.good_run = '0;
                        state_d.bad_run  = '0;
                    end else begin
                        state_d.bad_run = bad_inc[W-1:0];
                    end
                end
                default: state_d.st = SYNC_LOST;
            endcase
        end
        chg_o = (state_d.st != state_q.st);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{st: SYNC_LOST, good_run: '0, bad_run: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = (state_q.st == SYNC_HELD);
endmodule

// File: rtl/rxs_event_latch.sv
module rxs_event_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic evt_o,
    output logic irq_o
);
    typedef struct packed {
        logic evt;
    } evt_t;

    evt_t evt_d, evt_q;

    always_comb begin
        evt_d.evt = set_i | (evt_q.evt & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign evt_o = evt_q.evt;
    assign irq_o = evt_q.evt & irq_en_i;
endmodule

// File: rtl/rx_sync_tracker.sv
module rx_sync_tracker #(
    parameter int TH_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            enable_i,
    input  logic            chk_valid_i,
    input  logic            chk_err_i,
    input  logic [TH_W-1:0] acq_thresh_i,
    input  logic [TH_W-1:0] loss_thresh_i,
    input  logic            evt_clr_i,
    input  logic            irq_en_i,
    output logic            sync_o,
    output logic            stat_sync_o,
    output logic            evt_o,
    output logic            irq_o
);
    logic [TH_W-1:0] acq_eff, loss_eff;
    logic            sync_chg;
    logic            sync_st;

    rxs_thresh_norm #(.W(TH_W)) u_acq_norm (
        .raw_i (acq_thresh_i),
        .eff_o (acq_eff)
    );

    rxs_thresh_norm #(.W(TH_W)) u_loss_norm (
        .raw_i (loss_thresh_i),
        .eff_o (loss_eff)
    );

    rxs_sync_fsm #(.W(TH_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .enable_i    (enable_i),
        .chk_valid_i (chk_valid_i),
        .chk_err_i   (chk_err_i),
        .acq_eff_i   (acq_eff),
        .loss_eff_i  (loss_eff),
        .sync_o      (sync_st),
        .chg_o       (sync_chg)
    );

    rxs_event_latch u_evt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (sync_chg),
        .clr_i    (evt_clr_i),
        .irq_en_i (irq_en_i),
        .evt_o    (evt_o),
        .irq_o    (irq_o)
    );

    assign sync_o      = sync_st;
    assign stat_sync_o = sync_st;
endmodule

// File: rtl/rx_sync_tracker_chk.sv
module rx_sync_tracker_chk #(
    parameter int TH_W = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            enable_i,
    input logic            chk_valid_i,
    input logic            chk_err_i,
    input logic [TH_W-1:0] acq_thresh_i,
    input logic [TH_W-1:0] loss_thresh_i,
    input logic            evt_clr_i,
    input logic            irq_en_i,
    input logic            sync_o,
    input logic            stat_sync_o,
    input logic            evt_o,
    input logic            irq_o
);
    AST_IRQ_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (evt_o && irq_en_i)); // R9
    AST_STAT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_sync_o == sync_o); // R10
    AST_DISABLED_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !sync_o); // R6
    AST_CHANGE_SETS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_o != $past(sync_o)) |-> evt_o); // R7
    AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_o && !evt_clr_i) |=> evt_o); // R7
    AST_RISE_ON_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync_o) |-> $past(chk_valid_i && !chk_err_i && enable_i)); // R2
    AST_FALL_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sync_o) |-> $past(!enable_i || (chk_valid_i && chk_err_i))); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !chk_valid_i) |=> $stable(sync_o)); // R11
endmodule

bind rx_sync_tracker rx_sync_tracker_chk #(.TH_W(TH_W)) u_chk (.*);

// File: tb/rx_sync_tracker_test.sv
module rx_sync_tracker_test;
    localparam int TH_W = 4;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            enable_i = 1'b0;
    logic            chk_valid_i = 1'b0;
    logic            chk_err_i = 1'b0;
    logic [TH_W-1:0] acq_thresh_i = '0;
    logic [TH_W-1:0] loss_thresh_i = '0;
    logic            evt_clr_i = 1'b0;
    logic            irq_en_i = 1'b0;
    logic            sync_o, stat_sync_o, evt_o, irq_o;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    rx_sync_tracker #(.TH_W(TH_W)) uut (.*);

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic strobe(input logic err);
        @(negedge clk_i);
        chk_valid_i = 1'b1;
        chk_err_i   = err;
        @(negedge clk_i);
        chk_valid_i = 1'b0;
        chk_err_i   = 1'b0;
    endtask

    task automatic clear_evt();
        @(negedge clk_i);
        evt_clr_i = 1'b1;
        @(negedge clk_i);
        evt_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 sync", sync_o, 1'b0);
        check("R1 stat", stat_sync_o, 1'b0);
        check("R1 evt", evt_o, 1'b0);
        check("R1 irq", irq_o, 1'b0);
    endtask

    task automatic t_acquire();
        enable_i = 1'b1;
        acq_thresh_i = 4'd3;
        strobe(1'b0);
        strobe(1'b0);
        check("R2 early", sync_o, 1'b0);
        strobe(1'b0);
        check("R2 rise", sync_o, 1'b1);
        check("R10 stat", stat_sync_o, 1'b1);
        check("R7 rise evt", evt_o, 1'b1);
        check("R9 irq off", irq_o, 1'b0);
        irq_en_i = 1'b1;
        #1;
        check("R9 irq on", irq_o, 1'b1);
    endtask

    task automatic t_clear();
        clear_evt();
        check("R8 clear", evt_o, 1'b0);
        check("R9 irq low", irq_o, 1'b0);
    endtask

    task automatic t_idle();
        loss_thresh_i = 4'd1;
        @(negedge clk_i);
        chk_err_i = 1'b1;
        repeat (20) @(negedge clk_i);
        chk_err_i = 1'b0;
        check("R11 idle sync", sync_o, 1'b1);
        check("R11 idle evt", evt_o, 1'b0);
    endtask

    task automatic t_loss();
        loss_thresh_i = 4'd2;
        strobe(1'b1);
        strobe(1'b0);
        strobe(1'b1);
        check("R5 good resets", sync_o, 1'b1);
        strobe(1'b1);
        check("R5 fall", sync_o, 1'b0);
        check("R7 fall evt", evt_o, 1'b1);
        clear_evt();
    endtask

    task automatic t_restart();
        acq_thresh_i = 4'd4;
        strobe(1'b0);
        strobe(1'b0);
        strobe(1'b1);
        strobe(1'b0);
        strobe(1'b0);
        strobe(1'b0);
        check("R3 restart", sync_o, 1'b0);
        strobe(1'b0);
        check("R3 reach", sync_o, 1'b1);
    endtask

    task automatic t_zero();
        loss_thresh_i = 4'd0;
        strobe(1'b1);
        check("R4 loss zero", sync_o, 1'b0);
        acq_thresh_i = 4'd0;
        strobe(1'b0);
        check("R4 acq zero", sync_o, 1'b1);
    endtask

    task automatic t_enable();
        clear_evt();
        @(negedge clk_i);
        enable_i = 1'b0;
        @(negedge clk_i);
        check("R6 drop", sync_o, 1'b0);
        check("R6 evt", evt_o, 1'b1);
        acq_thresh_i = 4'd1;
        for (int i = 0; i < 5; i++) strobe(1'b0);
        check("R6 held", sync_o, 1'b0);
        enable_i = 1'b1;
        clear_evt();
    endtask

    task automatic t_set_wins();
        @(negedge clk_i);
        chk_valid_i = 1'b1;
        chk_err_i   = 1'b0;
        evt_clr_i   = 1'b1;
        @(negedge clk_i);
        chk_valid_i = 1'b0;
        evt_clr_i   = 1'b0;
        check("R8 set wins sync", sync_o, 1'b1);
        check("R8 set wins evt", evt_o, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_acquire();
        t_clear();
        t_idle();
        t_loss();
        t_restart();
        t_zero();
        t_enable();
        t_set_wins();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk_i);
                n_run++;
                n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule